// File: doc/BRIEF.md
# Interrupt Priority Register Bank

This block holds one priority field per interrupt. Each field is eight bits wide. Four fields are packed into each 32-bit word. Software reaches the bank through a simple register port that accepts both whole-word and single-byte accesses. Only the upper `PRIO_BITS` bits of each field are stored. The low bits of each field always read back as zero. Writing all ones and reading the word back therefore shows which bits are implemented, and the same mask appears in all four byte lanes.

Byte addresses from `NUM_IRQ` upward lie beyond the implemented interrupts. They read as zero, and writes to them are dropped. A read is captured on the clock edge where `rd_en` is high, and its data appears on `rdata` from the next cycle. `rdata` holds its value until the next read. Comparing priorities and delivering interrupts are handled by other blocks.

Top module: `prio_bank`

## Requirements
- R1: The word at byte offset 4k holds the fields of interrupts 4k to 4k+3. The field of interrupt 4k+j sits in bits [8j+7:8j].
- R2: In every byte lane, the low 8-`PRIO_BITS` bits always read as zero. Writing 32'hFFFFFFFF to a word and reading it back returns the implemented mask in all four lanes (32'hF8F8F8F8 for `PRIO_BITS`=5).
- R3: A word write stores the written value ANDed with the mask. Writing zero clears all four fields of the word.
- R4: Reset clears every field and `rdata` to zero.
- R5: When `rd_en` is high at a clock edge, `rdata` shows the result after that edge. If a write in the same cycle targets the same location, the read returns the contents from before the write.
- R6: Any access at byte address `NUM_IRQ` or above reads as zero. A write to such an address changes no field.
- R7: A byte read (`byte_sz`=1) returns the masked field of interrupt `addr` in `rdata[7:0]`, with `rdata[31:8]` at zero.
- R8: A byte write takes the field value from `wdata[7:0]` and changes only the field of interrupt `addr`. The other three fields of that word stay untouched.
- R9: `rdata` keeps its value in every cycle where `rd_en` is low.
- R10: Word accesses (`byte_sz`=0) ignore `addr[1:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Byte address into the bank |
| wdata | input | 32 | Write data (byte writes use bits 7:0) |
| byte_sz | input | 1 | 1 selects a byte access, 0 a word access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |

## Verification
Every word is filled with a different scrambled 32-bit pattern, and every word and byte is read back. This distinguishes a correct lane order and mask from swapped lanes and from mask bits leaking through. Byte writes carry non-zero junk in `wdata[31:8]` and go to every interrupt in turn, which exposes writes that spill into neighbouring lanes or take the wrong data bits. The whole out-of-range address space is then written with all ones. Reading the in-range words afterwards separates true dropping of those writes from wrap-around aliasing. Misaligned word addresses, a read and a write to the same word in one cycle, and idle cycles after a read cover the address decode, the read ordering and the hold behaviour.

// File: rtl/prio_bank.sv
module prio_bank #(
  parameter int NUM_IRQ   = 64,
  parameter int PRIO_BITS = 5,
  parameter int AW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          byte_sz,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [31:0]   rdata
);
  localparam int LOW = 8 - PRIO_BITS;
  localparam int WW  = AW - 2;
  localparam logic [7:0]  LANE_MASK = 8'(8'hFF << LOW);
  localparam logic [31:0] WORD_MASK = {4{LANE_MASK}};

  logic [PRIO_BITS-1:0] fld_q [NUM_IRQ];
  logic [WW-1:0]        word_idx;
  logic [1:0]           lane;
  logic [31:0]          rd_word;
  logic [31:0]          rd_next;

  assign word_idx = addr[AW-1:2];
  assign lane     = addr[1:0];

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (word_idx == WW'(i / 4))
        rd_word[8*(i%4) +: 8] = 8'(8'(fld_q[i]) << LOW);
  end

  assign rd_next = byte_sz ? {24'h0, rd_word[8*lane +: 8]} : rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IRQ; i++) fld_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (word_idx == WW'(i / 4)) begin
          if (!byte_sz)
            fld_q[i] <= wdata[8*(i%4)+7 -: PRIO_BITS];
          else if (lane == 2'(i % 4))
            fld_q[i] <= wdata[7 -: PRIO_BITS];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~WORD_MASK) == 32'h0); // R2

  AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (32'(addr) >= NUM_IRQ)) |=> rdata == 32'h0); // R6

  AST_BYTE_READ_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && byte_sz) |=> rdata[31:8] == 24'h0); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R9

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chk
    AST_BYTE_WRITE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && byte_sz && addr != AW'(g)) |=> $stable(fld_q[g])); // R8
    AST_FAR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (32'(addr) >= NUM_IRQ)) |=> $stable(fld_q[g])); // R6
  end
endmodule

// File: tb/tb_prio_bank.sv
`timescale 1ns/1ps
module tb_prio_bank;
  localparam int NUM_IRQ = 64;
  localparam int PB      = 5;
  localparam int AW      = 8;
  localparam int NW      = NUM_IRQ / 4;
  localparam logic [7:0] M = 8'(8'hFF << (8 - PB));

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic byte_sz = 0, wr_en = 0, rd_en = 0;
  logic [31:0] rdata;
  int total = 0, bad = 0;
  logic [7:0] mdl [NUM_IRQ];
  logic [31:0] got;

  prio_bank #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PB), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .byte_sz(byte_sz), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] pat(int w);
    return (32'(w) * 32'h9E3779B1) ^ 32'hA5A55A5A;
  endfunction

  function automatic logic [31:0] exp_word(int k);
    return {mdl[4*k+3], mdl[4*k+2], mdl[4*k+1], mdl[4*k]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d, logic sz);
    @(negedge clk);
    addr = AW'(a); wdata = d; byte_sz = sz; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int a, logic sz, output logic [31:0] v);
    @(negedge clk);
    addr = AW'(a); byte_sz = sz; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    v = rdata;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM_IRQ; i++) mdl[i] = 8'h0;
    repeat (3) @(negedge clk);
    check("R4 rdata after reset", rdata, 32'h0);
    rst_n = 1;
    for (int w = 0; w < NW; w++) begin
      rd(4*w, 0, got);
      check("R4 reset field", got, 32'h0);
    end

    wr(0, 32'hFFFFFFFF, 0);
    rd(0, 0, got);
    check("R2 all-ones mask", got, {4{M}});

    for (int w = 0; w < NW; w++) begin
      wr(4*w, pat(w), 0);
      for (int j = 0; j < 4; j++) mdl[4*w+j] = pat(w)[8*j +: 8] & M;
    end
    for (int w = 0; w < NW; w++) begin
      rd(4*w, 0, got);
      check("R3 word readback", got, pat(w) & {4{M}});
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      rd(i, 1, got);
      check("R1 R7 byte read lane", got, {24'h0, pat(i/4)[8*(i%4) +: 8] & M});
    end

    wr(12, 32'h0, 0);
    for (int j = 0; j < 4; j++) mdl[12+j] = 8'h0;
    rd(12, 0, got);
    check("R3 zero clears", got, 32'h0);

    for (int i = 0; i < NUM_IRQ; i++) begin
      logic [7:0] b;
      b = 8'(i * 37 + 11);
      wr(i, {24'hC3C3C3 ^ 24'(i), b}, 1);
      mdl[i] = b & M;
      rd(4*(i/4), 0, got);
      check("R8 byte write local", got, exp_word(i/4));
    end

    for (int a = NUM_IRQ; a < (1 << AW); a += 4) begin
      wr(a, 32'hFFFFFFFF, 0);
      wr(a + 1, 32'hFFFFFFFF, 1);
      rd(a, 0, got);
      check("R6 far word reads zero", got, 32'h0);
      rd(a + 1, 1, got);
      check("R6 far byte reads zero", got, 32'h0);
    end
    for (int w = 0; w < NW; w++) begin
      rd(4*w, 0, got);
      check("R6 far writes dropped", got, exp_word(w));
    end

    wr(4*5 + 2, 32'h12345678, 0);
    for (int j = 0; j < 4; j++) mdl[20+j] = 32'h12345678 >> (8*j) & M;
    rd(4*5 + 3, 0, got);
    check("R10 misaligned word", got, exp_word(5));
    rd(4*6, 0, got);
    check("R10 neighbour untouched", got, exp_word(6));

    rd(4*7, 0, got);
    @(negedge clk); addr = 8'h04; byte_sz = 1;
    repeat (3) @(negedge clk);
    check("R9 rdata holds", rdata, exp_word(7));

    @(negedge clk);
    addr = 8'(4*9); byte_sz = 0; wdata = 32'hFFFFFFFF; wr_en = 1; rd_en = 1;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check("R5 read before write", rdata, exp_word(9));
    for (int j = 0; j < 4; j++) mdl[36+j] = M;
    rd(4*9, 0, got);
    check("R5 write landed", got, exp_word(9));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule